// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a true dual-port memory and watches the left and right access ports. When both ports are enabled and present the same address, it decides which port got there later. That port receives an active-low busy indication and has its write strobe suppressed. The earlier port proceeds untouched. Arrival order is judged in whole clock cycles. Each port records the cycle in which its enable went active or its address last changed. A same-cycle tie goes against the right port.

In master mode the block produces both busy outputs itself. In slave mode both busy outputs rest high, and busy indications from an external master arrive on dedicated inputs; an asserted busy input only gates that port's writes. The mode input is fixed for the whole time between resets. A build parameter selects a reduced-depth variant in which the topmost address bit is left out of the comparison.

Top module: `dpc_arbiter`

## Requirements
- R1: With both enables low but the compared address bits different, both busy outputs are high.
- R2: With either enable high, both busy outputs are high. Immediately after reset with both enables high, both busy outputs are high and both write grants are low.
- R3: In master mode, when a match forms, the port that became enabled or changed address in a later cycle than the other drives its busy output low in that same cycle.
- R4: In master mode, when both ports become fresh in the same cycle and match, the right port is the one given busy.
- R5: The two busy outputs are never low at the same time.
- R6: A busy output stays low for as long as the match persists, even if the winning port re-presents the same address. It returns high in the first cycle in which the addresses differ or an enable is high.
- R7: In master mode, a port whose busy output is low has its write grant held low, whatever its write strobe does.
- R8: In slave mode, both busy outputs stay high. A low busy input forces that port's write grant low, and the internal comparison has no effect on the grants.
- R9: With the reduced-depth parameter set, addresses differing only in the top bit count as a match. In the full-depth build they do not.
- R10: A write grant is high exactly when the port's enable is low, its write strobe is low, and the port is not blocked by busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 selects slave behaviour, held fixed after reset |
| l_en_n | input | 1 | Left port enable, active low |
| l_wr_n | input | 1 | Left port write strobe, active low |
| l_addr | input | ADDR_W | Left port address |
| l_busy_in_n | input | 1 | Left busy from external master (slave mode) |
| l_busy_n | output | 1 | Left busy, active low (master mode) |
| l_wr_ok | output | 1 | Left write grant to the memory array |
| r_en_n | input | 1 | Right port enable, active low |
| r_wr_n | input | 1 | Right port write strobe, active low |
| r_addr | input | ADDR_W | Right port address |
| r_busy_in_n | input | 1 | Right busy from external master (slave mode) |
| r_busy_n | output | 1 | Right busy, active low (master mode) |
| r_wr_ok | output | 1 | Right write grant to the memory array |

## Verification
The hold property for busy assumes that no port enables during the two cycles after reset release, while the synchronised reset still holds the arrival trackers clear. The stimulus keeps both enables high for several cycles after each reset. The properties also take the mode input to be constant outside reset. The bench changes it only while reset is asserted, and changes every other input only a nanosecond after the rising edge.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    LOSER_NONE  = 2'd0,
    LOSER_LEFT  = 2'd1,
    LOSER_RIGHT = 2'd2
  } loser_e;

  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;
  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/dpc_rst_sync.sv
module dpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dpc_port_track.sv
// Records whether a port's request is new this cycle: enable just went
// active, or the compared address changed while enabled.
module dpc_port_track #(
  parameter int unsigned KEY_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic [KEY_W-1:0] key,
  output logic             fresh
);
  logic             act_q, act_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic             key_ld;

  always_comb begin
    act_d  = !en_n;
    key_ld = !en_n;
    key_d  = key_ld ? key : key_q;
    fresh  = !en_n && (!act_q || (key != key_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      key_q <= '0;
    end else begin
      act_q <= act_d;
      key_q <= key_d;
    end
  end
endmodule

// File: rtl/dpc_addr_cmp.sv
// Selects the compared address slice and flags a live collision.
module dpc_addr_cmp #(
  parameter int unsigned ADDR_W   = 13,
  parameter bit          SKIP_TOP = 1'b0,
  localparam int unsigned KEY_W   = ADDR_W - (SKIP_TOP ? 1 : 0)
) (
  input  logic              l_en_n,
  input  logic              r_en_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic [KEY_W-1:0]  l_key,
  output logic [KEY_W-1:0]  r_key,
  output logic              match
);
  generate
    if (SKIP_TOP) begin : g_reduced
      logic l_top_unused, r_top_unused;
      assign l_key = l_addr[KEY_W-1:0];
      assign r_key = r_addr[KEY_W-1:0];
      assign l_top_unused = l_addr[ADDR_W-1];
      assign r_top_unused = r_addr[ADDR_W-1];
    end else begin : g_full
      assign l_key = l_addr;
      assign r_key = r_addr;
    end
  endgenerate

  always_comb begin
    match = !l_en_n && !r_en_n && (l_key == r_key);
  end
endmodule

// File: rtl/dpc_lock_fsm.sv
// Chooses the losing port when a match forms and holds it while it lasts.
module dpc_lock_fsm
  import dpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   match,
  input  logic   l_fresh,
  input  logic   r_fresh,
  output loser_e loser
);
  loser_e state_q, state_d;
  loser_e decided;

  always_comb begin
    // Left strictly later loses; a tie or right-later goes against right.
    decided = (l_fresh && !r_fresh) ? LOSER_LEFT : LOSER_RIGHT;
    if (!match)                     loser = LOSER_NONE;
    else if (state_q != LOSER_NONE) loser = state_q;
    else                            loser = decided;
    state_d = loser;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LOSER_NONE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/dpc_write_gate.sv
// Per-port busy drive and write suppression.
module dpc_write_gate (
  input  logic slave_mode,
  input  logic en_n,
  input  logic wr_n,
  input  logic busy_in_n,
  input  logic lose,
  output logic busy_n,
  output logic wr_ok
);
  logic blocked;

  always_comb begin
    blocked = slave_mode ? !busy_in_n : lose;
    busy_n  = slave_mode ? 1'b1 : !lose;
    wr_ok   = !en_n && !wr_n && !blocked;
  end
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter bit          SKIP_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_en_n,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_in_n,
  output logic              l_busy_n,
  output logic              l_wr_ok,
  input  logic              r_en_n,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_in_n,
  output logic              r_busy_n,
  output logic              r_wr_ok
);
  localparam int unsigned KEY_W = ADDR_W - (SKIP_TOP ? 1 : 0);

  logic             rst_n_int;
  logic [KEY_W-1:0] l_key, r_key;
  logic             match;
  logic             l_fresh, r_fresh;
  loser_e           loser;

  logic [NUM_SIDES-1:0] en_n_v, wr_n_v, bin_n_v, lose_v, busy_n_v, wr_ok_v;

  dpc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  dpc_addr_cmp #(.ADDR_W(ADDR_W), .SKIP_TOP(SKIP_TOP)) u_cmp (
    .l_en_n(l_en_n), .r_en_n(r_en_n), .l_addr(l_addr), .r_addr(r_addr),
    .l_key(l_key), .r_key(r_key), .match(match)
  );

  dpc_port_track #(.KEY_W(KEY_W)) u_trk_l (
    .clk(clk), .rst_n(rst_n_int), .en_n(l_en_n), .key(l_key), .fresh(l_fresh)
  );

  dpc_port_track #(.KEY_W(KEY_W)) u_trk_r (
    .clk(clk), .rst_n(rst_n_int), .en_n(r_en_n), .key(r_key), .fresh(r_fresh)
  );

  dpc_lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int), .match(match),
    .l_fresh(l_fresh), .r_fresh(r_fresh), .loser(loser)
  );

  always_comb begin
    en_n_v[SIDE_L]  = l_en_n;      en_n_v[SIDE_R]  = r_en_n;
    wr_n_v[SIDE_L]  = l_wr_n;      wr_n_v[SIDE_R]  = r_wr_n;
    bin_n_v[SIDE_L] = l_busy_in_n; bin_n_v[SIDE_R] = r_busy_in_n;
    lose_v[SIDE_L]  = (loser == LOSER_LEFT);
    lose_v[SIDE_R]  = (loser == LOSER_RIGHT);
  end

  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      dpc_write_gate u_gate (
        .slave_mode(slave_mode), .en_n(en_n_v[s]), .wr_n(wr_n_v[s]),
        .busy_in_n(bin_n_v[s]), .lose(lose_v[s]),
        .busy_n(busy_n_v[s]), .wr_ok(wr_ok_v[s])
      );
    end
  endgenerate

  assign l_busy_n = busy_n_v[SIDE_L];
  assign r_busy_n = busy_n_v[SIDE_R];
  assign l_wr_ok  = wr_ok_v[SIDE_L];
  assign r_wr_ok  = wr_ok_v[SIDE_R];
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
  parameter int unsigned ADDR_W   = 13,
  parameter bit          SKIP_TOP = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode,
  input logic              l_en_n,
  input logic              l_wr_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_in_n,
  input logic              l_busy_n,
  input logic              l_wr_ok,
  input logic              r_en_n,
  input logic              r_wr_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_in_n,
  input logic              r_busy_n,
  input logic              r_wr_ok
);
  localparam int unsigned KEY_W = ADDR_W - (SKIP_TOP ? 1 : 0);
  logic same;
  assign same = (l_addr[KEY_W-1:0] == r_addr[KEY_W-1:0]);

  p_diff_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!same) |-> (l_busy_n && r_busy_n));
  p_enable_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en_n || r_en_n) |-> (l_busy_n && r_busy_n));
  p_one_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));
  p_hold_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n) |=> (l_en_n || r_en_n || !same || !l_busy_n));
  p_hold_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n) |=> (l_en_n || r_en_n || !same || !r_busy_n));
  p_block_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n) |-> !l_wr_ok);
  p_block_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n) |-> !r_wr_ok);
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (l_busy_n && r_busy_n));
  p_slave_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && (!l_busy_in_n || !r_busy_in_n)) |->
      ((l_busy_in_n || !l_wr_ok) && (r_busy_in_n || !r_wr_ok)));
  p_grant_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en_n && !l_wr_n && !slave_mode && l_busy_n) |-> l_wr_ok);
  p_grant_right_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_en_n && !r_wr_n && slave_mode && r_busy_in_n) |-> r_wr_ok);
  p_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(slave_mode));
endmodule

bind dpc_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W), .SKIP_TOP(SKIP_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
  .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
  .l_busy_n(l_busy_n), .l_wr_ok(l_wr_ok),
  .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
  .r_busy_n(r_busy_n), .r_wr_ok(r_wr_ok)
);

// File: tb/dpc_arbiter_test.sv
module dpc_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic l_en_n = 1'b1, l_wr_n = 1'b1, l_busy_in_n = 1'b1;
  logic r_en_n = 1'b1, r_wr_n = 1'b1, r_busy_in_n = 1'b1;
  logic [12:0] l_addr = '0, r_addr = '0;
  logic l_busy_n, l_wr_ok, r_busy_n, r_wr_ok;
  logic nl_busy_n, nl_wr_ok, nr_busy_n, nr_wr_ok;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R2";

  always #2 clk = ~clk;

  dpc_arbiter #(.ADDR_W(13), .SKIP_TOP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
    .l_busy_n(l_busy_n), .l_wr_ok(l_wr_ok),
    .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
    .r_busy_n(r_busy_n), .r_wr_ok(r_wr_ok));

  dpc_arbiter #(.ADDR_W(13), .SKIP_TOP(1'b1)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
    .l_busy_n(nl_busy_n), .l_wr_ok(nl_wr_ok),
    .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
    .r_busy_n(nr_busy_n), .r_wr_ok(nr_wr_ok));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference: arrival cycle per port, current loser per instance.
  bit m_lpen[2], m_rpen[2];
  int m_lpa[2], m_rpa[2], m_ls[2], m_rs[2], m_los[2];
  int cyc = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_lpen[i] = 0; m_rpen[i] = 0; m_lpa[i] = 0; m_rpa[i] = 0;
        m_ls[i] = 0; m_rs[i] = 0; m_los[i] = 0;
      end
      cyc = 1;
    end else begin
      for (int i = 0; i < 2; i++) begin
        int mask, lk, rk, ls, rs, los;
        bit le, re, lf, rf, hit, lblk, rblk;
        logic xl_b, xr_b, xl_w, xr_w, al_b, ar_b, al_w, ar_w;
        mask = (i == 0) ? 'h1FFF : 'h0FFF;
        lk = int'(l_addr) & mask;
        rk = int'(r_addr) & mask;
        le = !l_en_n; re = !r_en_n;
        lf = le && (!m_lpen[i] || lk != m_lpa[i]);
        rf = re && (!m_rpen[i] || rk != m_rpa[i]);
        ls = lf ? cyc : m_ls[i];
        rs = rf ? cyc : m_rs[i];
        hit = le && re && (lk == rk);
        if (!hit) los = 0;
        else if (m_los[i] != 0) los = m_los[i];
        else los = (ls > rs) ? 1 : 2;
        lblk = slave_mode ? !l_busy_in_n : (los == 1);
        rblk = slave_mode ? !r_busy_in_n : (los == 2);
        xl_b = slave_mode ? 1'b1 : !(los == 1);
        xr_b = slave_mode ? 1'b1 : !(los == 2);
        xl_w = le && !l_wr_n && !lblk;
        xr_w = re && !r_wr_n && !rblk;
        al_b = (i == 0) ? l_busy_n : nl_busy_n;
        ar_b = (i == 0) ? r_busy_n : nr_busy_n;
        al_w = (i == 0) ? l_wr_ok : nl_wr_ok;
        ar_w = (i == 0) ? r_wr_ok : nr_wr_ok;
        if (chk_on) begin
          chk({cur_tag, " left busy"}, al_b, xl_b);
          chk({cur_tag, " right busy"}, ar_b, xr_b);
          chk({cur_tag, " left grant"}, al_w, xl_w);
          chk({cur_tag, " right grant"}, ar_w, xr_w);
          chk("R5 both busy low", al_b | ar_b, 1'b1);
        end
        m_lpen[i] = le; m_rpen[i] = re;
        if (le) m_lpa[i] = lk;
        if (re) m_rpa[i] = rk;
        m_ls[i] = ls; m_rs[i] = rs; m_los[i] = los;
      end
      cyc++;
    end
  end

  task automatic drive(input bit le, input int la, input bit lw,
                       input bit re, input int ra, input bit rw);
    @(posedge clk); #1;
    l_en_n = !le; l_addr = 13'(la); l_wr_n = !lw;
    r_en_n = !re; r_addr = 13'(ra); r_wr_n = !rw;
  endtask

  task automatic do_reset(input logic mode);
    @(posedge clk); #1;
    chk_on = 0; rst_n = 0; slave_mode = mode;
    l_en_n = 1; r_en_n = 1; l_wr_n = 1; r_wr_n = 1;
    l_busy_in_n = 1; r_busy_in_n = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    chk("R2 reset left busy", l_busy_n, 1'b1);
    chk("R2 reset right busy", r_busy_n, 1'b1);
    chk("R2 reset left grant", l_wr_ok, 1'b0);
    chk("R2 reset right grant", r_wr_ok, 1'b0);
    chk_on = 1;

    cur_tag = "R1";
    drive(1, 'h010, 1, 1, 'h011, 1);
    @(negedge clk);
    chk("R1 diff addr left busy", l_busy_n, 1'b1);
    chk("R10 diff addr left grant", l_wr_ok, 1'b1);
    chk("R10 diff addr right grant", r_wr_ok, 1'b1);

    cur_tag = "R3";
    drive(0, 0, 0, 1, 'h040, 0);
    drive(0, 0, 0, 1, 'h040, 1);
    drive(1, 'h040, 1, 1, 'h040, 1);
    @(negedge clk);
    chk("R3 left later busy", l_busy_n, 1'b0);
    chk("R3 right stays free", r_busy_n, 1'b1);
    chk("R7 left write blocked", l_wr_ok, 1'b0);
    chk("R10 right write passes", r_wr_ok, 1'b1);

    cur_tag = "R6";
    drive(1, 'h040, 1, 1, 'h040, 0);
    drive(1, 'h040, 1, 1, 'h040, 1);
    @(negedge clk);
    chk("R6 left busy held", l_busy_n, 1'b0);
    drive(1, 'h040, 1, 1, 'h041, 1);
    @(negedge clk);
    chk("R6 left busy released", l_busy_n, 1'b1);
    chk("R6 left write resumes", l_wr_ok, 1'b1);

    cur_tag = "R3";
    drive(1, 'h040, 1, 1, 'h040, 1);
    @(negedge clk);
    chk("R3 right later busy", r_busy_n, 1'b0);
    chk("R3 left free", l_busy_n, 1'b1);
    chk("R7 right write blocked", r_wr_ok, 1'b0);

    cur_tag = "R2";
    drive(1, 'h040, 1, 0, 'h040, 1);
    @(negedge clk);
    chk("R2 right enable off releases", l_busy_n & r_busy_n, 1'b1);

    cur_tag = "R4";
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 'h007, 1, 1, 'h007, 1);
    @(negedge clk);
    chk("R4 tie right busy", r_busy_n, 1'b0);
    chk("R4 tie left free", l_busy_n, 1'b1);

    cur_tag = "R9";
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 'h1005, 1, 1, 'h0005, 1);
    @(negedge clk);
    chk("R9 full build no match", r_busy_n & l_busy_n, 1'b1);
    chk("R9 reduced build match", nr_busy_n, 1'b0);
    chk("R9 reduced build write blocked", nr_wr_ok, 1'b0);

    cur_tag = "R5";
    for (int k = 0; k < 600; k++) begin
      int pick_l, pick_r;
      pick_l = $urandom_range(0, 2);
      pick_r = $urandom_range(0, 2);
      drive($urandom_range(0, 3) != 0, (pick_l == 2) ? 'h1000 : pick_l, $urandom_range(0, 1) == 1,
            $urandom_range(0, 3) != 0, (pick_r == 2) ? 'h1000 : pick_r, $urandom_range(0, 1) == 1);
    end

    do_reset(1'b1);
    chk_on = 1;
    cur_tag = "R8";
    drive(1, 'h020, 1, 1, 'h020, 1);
    #0 l_busy_in_n = 0;
    @(negedge clk);
    chk("R8 slave left busy out high", l_busy_n, 1'b1);
    chk("R8 slave right busy out high", r_busy_n, 1'b1);
    chk("R8 slave left write blocked", l_wr_ok, 1'b0);
    chk("R8 slave right write passes", r_wr_ok, 1'b1);
    for (int k = 0; k < 300; k++) begin
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 2), $urandom_range(0, 1) == 1,
            $urandom_range(0, 3) != 0, $urandom_range(0, 2), $urandom_range(0, 1) == 1);
      l_busy_in_n = $urandom_range(0, 1) == 1;
      r_busy_in_n = $urandom_range(0, 1) == 1;
    end
    @(negedge clk);
    chk_on = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule